// File: doc/BRIEF.md
# Decrement-and-Skip Instruction Executor

This block executes the two conditional-skip instructions of a small 8-bit accumulator core that decrement a data register. One of them skips when the decremented value is zero, and the other skips when it is non-zero. Each instruction cycle runs through four internal phases. In the first phase the block accepts a 16-bit instruction word and a bank select value. It then forms a 12-bit data address and reads the register at that address. Next it decrements the value and writes the result either to the working register or back to the data register.

When the skip condition holds, the instruction that the fetch stage has already brought in is discarded. The block flags one squash cycle in its place, or two when that discarded instruction is a two-word instruction. The program counter advances by one word for every instruction cycle, whether the cycle executes or squashes. The data registers sit in a synchronous array inside the block. The rest of the core fills that array through a plain write port.

Top module: `dsk_exec`

## Requirements
- R1: An instruction word is executed only when its bits [15:10] equal 6'b001011 (skip on zero) or 6'b010011 (skip on non-zero). Any other word changes neither the data registers, the working register nor the squash state.
- R2: Bit 9 selects the destination. When it is 0 the decremented value goes to the working register and the data register keeps its value. When it is 1 the value is written back to the data register and the working register keeps its value.
- R3: Bits [7:0] give the register offset. When bit 8 is 1, the upper address bits come from the bank select input sampled with the instruction. When bit 8 is 0 that input is ignored: offsets below 0x80 map to bank 0, and offsets 0x80 and above map to the all-ones bank.
- R4: The phase output counts 0, 1, 2, 3 and then repeats. The instruction word is sampled in phase 0. Every effect of an instruction appears on the clock edge that ends phase 3.
- R5: The decrement wraps, so 0x00 becomes 0xFF. The skip test uses that wrapped 8-bit result.
- R6: A skip-on-zero instruction whose result is 0x00 makes squash_o high for the whole next instruction cycle.
- R7: A skip-on-non-zero instruction whose result is not 0x00 makes squash_o high for the whole next instruction cycle.
- R8: If next_two_word_i was high when the skipping instruction was sampled, squash_o stays high for exactly two instruction cycles instead of one.
- R9: The instruction word presented during a squash cycle is ignored and has no effect on any register.
- R10: pc_o advances by one at the end of every instruction cycle and wraps modulo 2^PC_W.
- R11: After reset, phase_o, pc_o, wreg_o and squash_o are all zero.
- R12: The write port loads the data register at mem_waddr_i on any clock where mem_we_i is high. If the instruction writes in the same cycle, the instruction's write takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word, sampled in phase 0 |
| next_two_word_i | input | 1 | The prefetched following instruction occupies two words |
| bsr_i | input | BANK_W | Bank select value, sampled in phase 0 |
| mem_we_i | input | 1 | Data register load strobe |
| mem_waddr_i | input | BANK_W+8 | Data register load address |
| mem_wdata_i | input | DATA_W | Data register load value |
| phase_o | output | 2 | Current phase within the instruction cycle |
| squash_o | output | 1 | Current instruction cycle is a discarded one |
| pc_o | output | PC_W | Program counter in words |
| wreg_o | output | DATA_W | Working register |

## Verification
The bench builds the block with BANK_W=4, DATA_W=8, ACCESS_SPLIT=128 and PC_W=8. The narrow counter lets a run of a few hundred instruction cycles cross the wrap from 0xFF to 0x00. The full 12-bit address makes the all-ones access bank distinct from every banked address the bench uses. The split of 128 places access offsets on both sides of the boundary, so both mappings are exercised. The bench preloads registers holding 0x00, 0x01 and 0x80. These reach the zero result, the wrap to 0xFF, and the two opposite skip decisions. The bench also places live instructions in squash slots, which shows they are discarded.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
   localparam int IW_W   = 16;
   localparam int FSEL_W = 8;
   localparam logic [5:0] OPC_ZSKIP  = 6'b001011;
   localparam logic [5:0] OPC_NZSKIP = 6'b010011;

   typedef enum logic [1:0] {
      PH_DECODE = 2'd0,
      PH_READ   = 2'd1,
      PH_PROC   = 2'd2,
      PH_WRITE  = 2'd3
   } phase_e;

   typedef struct packed {
      logic [5:0]        opc;
      logic              dst_f;
      logic              banked;
      logic [FSEL_W-1:0] fsel;
   } iword_t;
endpackage

// File: rtl/dsk_decode.sv
module dsk_decode
   import dsk_pkg::*;
#(
   parameter int BANK_W       = 4,
   parameter int ACCESS_SPLIT = 128
) (
   input  iword_t                   ir,
   input  logic [BANK_W-1:0]        bsr,
   output logic                     hit,
   output logic                     on_zero,
   output logic                     dst_f,
   output logic [BANK_W+FSEL_W-1:0] addr
);
   localparam logic [FSEL_W:0] SPLIT = (FSEL_W+1)'(ACCESS_SPLIT);

   logic [BANK_W-1:0] acc_bank;

   generate
      if (ACCESS_SPLIT >= (1 << FSEL_W)) begin : g_flat
         assign acc_bank = '0;
      end else begin : g_split
         assign acc_bank = ({1'b0, ir.fsel} >= SPLIT) ? '1 : '0;
      end
   endgenerate

   always_comb begin
      hit     = (ir.opc == OPC_ZSKIP) || (ir.opc == OPC_NZSKIP);
      on_zero = (ir.opc == OPC_ZSKIP);
      dst_f   = ir.dst_f;
      addr    = {(ir.banked ? bsr : acc_bank), ir.fsel};
   end
endmodule

// File: rtl/dsk_regfile.sv
module dsk_regfile #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   input  logic              core_we,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [DATA_W-1:0] core_data,
   input  logic              ext_we,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic [DATA_W-1:0] ext_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rd_en) rdata <= mem[raddr];
      if (core_we)     mem[core_addr] <= core_data;
      else if (ext_we) mem[ext_addr]  <= ext_data;
   end
endmodule

// File: rtl/dsk_seq.sv
module dsk_seq
   import dsk_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            skip_set,
   input  logic            skip_two,
   output phase_e          phase,
   output logic            squash,
   output logic            accept,
   output logic [PC_W-1:0] pc
);
   logic [1:0] ph_q;
   logic [1:0] skip_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= 2'd0;
         skip_q <= 2'd0;
         pc     <= '0;
      end else begin
         ph_q <= ph_q + 2'd1;
         if (ph_q == 2'd3) begin
            pc <= pc + 1'b1;
            if (skip_set)           skip_q <= skip_two ? 2'd2 : 2'd1;
            else if (skip_q != 2'd0) skip_q <= skip_q - 2'd1;
         end
      end
   end

   always_comb begin
      phase  = phase_e'(ph_q);
      squash = (skip_q != 2'd0);
      accept = (ph_q == 2'd0) && (skip_q == 2'd0);
   end
endmodule

// File: rtl/dsk_exec.sv
module dsk_exec
   import dsk_pkg::*;
#(
   parameter int BANK_W       = 4,
   parameter int DATA_W       = 8,
   parameter int PC_W         = 16,
   parameter int ACCESS_SPLIT = 128
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [IW_W-1:0]          instr_i,
   input  logic                     next_two_word_i,
   input  logic [BANK_W-1:0]        bsr_i,
   input  logic                     mem_we_i,
   input  logic [BANK_W+FSEL_W-1:0] mem_waddr_i,
   input  logic [DATA_W-1:0]        mem_wdata_i,
   output logic [1:0]               phase_o,
   output logic                     squash_o,
   output logic [PC_W-1:0]          pc_o,
   output logic [DATA_W-1:0]        wreg_o
);
   localparam int ADDR_W = BANK_W + FSEL_W;

   generate
      if (BANK_W < 1 || BANK_W > 4) begin : g_bad_bank
         $error("dsk_exec: BANK_W must lie in 1..4");
      end
      if (DATA_W < 2 || DATA_W > 32) begin : g_bad_data
         $error("dsk_exec: DATA_W must lie in 2..32");
      end
      if (PC_W < 2) begin : g_bad_pc
         $error("dsk_exec: PC_W must be at least 2");
      end
      if (ACCESS_SPLIT < 0) begin : g_bad_split
         $error("dsk_exec: ACCESS_SPLIT must not be negative");
      end
   endgenerate

   phase_e              phase;
   logic                accept;
   iword_t              ir_q;
   logic [BANK_W-1:0]   bsr_q;
   logic                valid_q;
   logic                two_q;
   logic                hit, on_zero, dst_f;
   logic [ADDR_W-1:0]   addr;
   logic [DATA_W-1:0]   rdata;
   logic [DATA_W-1:0]   res_q;
   logic                retire;
   logic                exec;
   logic                take;
   logic                core_we;

   dsk_seq #(.PC_W(PC_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .skip_set (retire & take),
      .skip_two (two_q),
      .phase    (phase),
      .squash   (squash_o),
      .accept   (accept),
      .pc       (pc_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ir_q    <= '0;
         bsr_q   <= '0;
         valid_q <= 1'b0;
         two_q   <= 1'b0;
      end else if (phase == PH_DECODE) begin
         valid_q <= accept;
         if (accept) begin
            ir_q  <= iword_t'(instr_i);
            bsr_q <= bsr_i;
            two_q <= next_two_word_i;
         end
      end
   end

   dsk_decode #(.BANK_W(BANK_W), .ACCESS_SPLIT(ACCESS_SPLIT)) u_dec (
      .ir      (ir_q),
      .bsr     (bsr_q),
      .hit     (hit),
      .on_zero (on_zero),
      .dst_f   (dst_f),
      .addr    (addr)
   );

   dsk_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
      .clk       (clk),
      .rd_en     (phase == PH_READ),
      .raddr     (addr),
      .rdata     (rdata),
      .core_we   (core_we),
      .core_addr (addr),
      .core_data (res_q),
      .ext_we    (mem_we_i),
      .ext_addr  (mem_waddr_i),
      .ext_data  (mem_wdata_i)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                res_q <= '0;
      else if (phase == PH_PROC) res_q <= rdata - 1'b1;
   end

   always_comb begin
      retire  = (phase == PH_WRITE);
      exec    = valid_q & hit;
      take    = exec & (on_zero ? (res_q == '0) : (res_q != '0));
      core_we = retire & exec & dst_f;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        wreg_o <= '0;
      else if (retire && exec && !dst_f) wreg_o <= res_q;
   end

   assign phase_o = phase;
endmodule

// File: rtl/dsk_exec_chk.sv
module dsk_exec_chk #(
   parameter int PC_W   = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        phase_o,
   input logic              squash_o,
   input logic [PC_W-1:0]   pc_o,
   input logic [DATA_W-1:0] wreg_o,
   input logic              core_we
);
   p_phase_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == 2'd3 |=> phase_o == 2'd0);

   p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o != 2'd3 |=> phase_o == $past(phase_o) + 2'd1);

   p_write_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_we |-> phase_o == 2'd3);

   p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o != 2'd3 |=> $stable(pc_o));

   p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == 2'd3 |=> pc_o == PC_W'($past(pc_o) + 1'b1));

   p_wreg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o != 2'd3 |=> $stable(wreg_o));

   p_squash_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o != 2'd3 |=> $stable(squash_o));

   p_squash_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      squash_o |-> !core_we);
endmodule

bind dsk_exec dsk_exec_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .phase_o  (phase_o),
   .squash_o (squash_o),
   .pc_o     (pc_o),
   .wreg_o   (wreg_o),
   .core_we  (core_we)
);

// File: tb/dsk_exec_tb.sv
`timescale 1ns/1ps
module dsk_exec_tb;
   localparam int BANK_W = 4;
   localparam int DATA_W = 8;
   localparam int PC_W   = 8;
   localparam int SPLIT  = 128;
   localparam logic [5:0] ZOP  = 6'b001011;
   localparam logic [5:0] NZOP = 6'b010011;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr_i = '0;
   logic        next_two_word_i = 1'b0;
   logic [3:0]  bsr_i = '0;
   logic        mem_we_i = 1'b0;
   logic [11:0] mem_waddr_i = '0;
   logic [7:0]  mem_wdata_i = '0;
   logic [1:0]  phase_o;
   logic        squash_o;
   logic [7:0]  pc_o;
   logic [7:0]  wreg_o;

   int vectors = 0;
   int miscompares = 0;
   logic last_sq;

   always #10 clk = ~clk;

   dsk_exec #(.BANK_W(BANK_W), .DATA_W(DATA_W), .PC_W(PC_W), .ACCESS_SPLIT(SPLIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .next_two_word_i(next_two_word_i),
      .bsr_i(bsr_i), .mem_we_i(mem_we_i), .mem_waddr_i(mem_waddr_i), .mem_wdata_i(mem_wdata_i),
      .phase_o(phase_o), .squash_o(squash_o), .pc_o(pc_o), .wreg_o(wreg_o)
   );

   // behavioural reference model, whole instruction resolved at the end of phase 3
   logic [7:0]  mmem [4096];
   int          m_ph, m_sk, m_nsk;
   logic [7:0]  m_pc, m_w, m_val;
   logic [15:0] m_ir;
   logic        m_two, m_v, m_cond;
   logic [3:0]  m_bsr;
   logic [11:0] m_addr;

   initial for (int i = 0; i < 4096; i++) mmem[i] = 8'h00;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_sk = 0; m_pc = 8'h00; m_w = 8'h00; m_v = 1'b0;
      end else begin
         if (mem_we_i) mmem[mem_waddr_i] = mem_wdata_i;
         if (m_ph == 0) begin
            if (m_sk == 0) begin
               m_ir = instr_i; m_two = next_two_word_i; m_bsr = bsr_i; m_v = 1'b1;
            end else m_v = 1'b0;
         end
         if (m_ph == 3) begin
            m_nsk = (m_sk > 0) ? m_sk - 1 : 0;
            if (m_v && (m_ir[15:10] == ZOP || m_ir[15:10] == NZOP)) begin
               if (m_ir[8])             m_addr = {m_bsr, m_ir[7:0]};
               else if (m_ir[7:0] >= SPLIT) m_addr = {4'hF, m_ir[7:0]};
               else                     m_addr = {4'h0, m_ir[7:0]};
               m_val = mmem[m_addr] - 8'd1;
               if (m_ir[9]) mmem[m_addr] = m_val;
               else         m_w = m_val;
               m_cond = (m_ir[15:10] == ZOP) ? (m_val == 8'h00) : (m_val != 8'h00);
               if (m_cond) m_nsk = m_two ? 2 : 1;
            end
            m_sk = m_nsk;
            m_pc = m_pc + 8'd1;
         end
         m_ph = (m_ph + 1) % 4;
      end
   end

   task automatic chk(input string tag, input int got, input int exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R4 phase", int'(phase_o), m_ph);
         chk("R10 pc", int'(pc_o), int'(m_pc));
         chk("R6/R7/R8 squash", int'(squash_o), int'(m_sk != 0));
         chk("R2/R5 wreg", int'(wreg_o), int'(m_w));
      end
   end

   function automatic logic [15:0] enc(input logic [5:0] op, input logic d,
                                       input logic a, input logic [7:0] f);
      return {op, d, a, f};
   endfunction

   task automatic issue(input logic [15:0] w, input logic two, input logic [3:0] b);
      while (phase_o != 2'd0) @(negedge clk);
      instr_i = w; next_two_word_i = two; bsr_i = b; last_sq = squash_o;
      repeat (4) @(negedge clk);
   endtask

   task automatic preload(input logic [11:0] a, input logic [7:0] d);
      mem_we_i = 1'b1; mem_waddr_i = a; mem_wdata_i = d;
      @(negedge clk);
      mem_we_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL R4 watchdog got hang expected completion");
      finish_run();
   end

   int unsigned lf = 32'h1234_5678;
   function automatic int unsigned nxt(input int unsigned s);
      return s * 32'd1103515245 + 32'd12345;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state (first cycle after release still in phase 1, pc 0)
      chk("R11 pc", int'(pc_o), 0);
      chk("R11 wreg", int'(wreg_o), 0);
      chk("R11 squash", int'(squash_o), 0);

      // R12 preload through the write port
      preload(12'h110, 8'h03); preload(12'h111, 8'h01);
      preload(12'h112, 8'h00); preload(12'h113, 8'h05);
      preload(12'h210, 8'h02); preload(12'h211, 8'h01);
      preload(12'h212, 8'h80); preload(12'h213, 8'h00);
      preload(12'h005, 8'h01); preload(12'hF85, 8'h10);

      // R6 zero result skips; R9 squashed word ignored
      issue(enc(ZOP, 1'b0, 1'b1, 8'h11), 1'b0, 4'h1);
      chk("R6 wreg", int'(wreg_o), 8'h00);
      issue(enc(ZOP, 1'b0, 1'b1, 8'h10), 1'b0, 4'h1);
      chk("R6 squash", int'(last_sq), 1);
      chk("R9 wreg unchanged", int'(wreg_o), 8'h00);

      // R5 wrap, R2 write back then read into wreg
      issue(enc(ZOP, 1'b1, 1'b1, 8'h12), 1'b0, 4'h1);
      chk("R2 wreg kept", int'(wreg_o), 8'h00);
      issue(enc(ZOP, 1'b0, 1'b1, 8'h12), 1'b0, 4'h1);
      chk("R5 no skip after wrap", int'(last_sq), 0);
      chk("R5 wreg", int'(wreg_o), 8'hFE);

      // R7 non-zero skip with two-word follower, R8 two squash cycles
      issue(enc(NZOP, 1'b0, 1'b1, 8'h10), 1'b1, 4'h1);
      chk("R7 wreg", int'(wreg_o), 8'h02);
      issue(enc(ZOP, 1'b0, 1'b1, 8'h11), 1'b0, 4'h1);
      chk("R7 squash first", int'(last_sq), 1);
      issue(enc(ZOP, 1'b0, 1'b1, 8'h13), 1'b0, 4'h1);
      chk("R8 squash second", int'(last_sq), 1);
      chk("R9 wreg unchanged", int'(wreg_o), 8'h02);
      issue(enc(ZOP, 1'b0, 1'b1, 8'h10), 1'b0, 4'h1);
      chk("R8 third cycle executes", int'(last_sq), 0);
      chk("R2 file unchanged by d=0", int'(wreg_o), 8'h02);

      // R3 access bank mapping, bank select ignored
      issue(enc(ZOP, 1'b0, 1'b0, 8'h05), 1'b0, 4'h2);
      chk("R3 low access", int'(wreg_o), 8'h00);
      issue(16'h0000, 1'b0, 4'h2);
      chk("R6 squash nop", int'(last_sq), 1);
      issue(enc(ZOP, 1'b0, 1'b0, 8'h85), 1'b0, 4'h2);
      chk("R3 high access", int'(wreg_o), 8'h0F);

      // R2 write back to zero, then R7 on the wrapped value
      issue(enc(ZOP, 1'b1, 1'b1, 8'h11), 1'b0, 4'h2);
      chk("R2 wreg kept", int'(wreg_o), 8'h0F);
      issue(16'h0000, 1'b0, 4'h2);
      chk("R6 squash after write back", int'(last_sq), 1);
      issue(enc(NZOP, 1'b0, 1'b1, 8'h11), 1'b0, 4'h2);
      chk("R5 wreg", int'(wreg_o), 8'hFF);
      issue(16'h0000, 1'b0, 4'h2);
      chk("R7 squash", int'(last_sq), 1);

      // R1 foreign opcode with the same field layout has no effect
      issue(16'h2B12, 1'b0, 4'h2);
      chk("R1 wreg unchanged", int'(wreg_o), 8'hFF);
      issue(enc(ZOP, 1'b0, 1'b1, 8'h12), 1'b0, 4'h2);
      chk("R1 no squash", int'(last_sq), 0);
      chk("R1 file unchanged", int'(wreg_o), 8'h7F);

      // mixed stream, model compared every clock; crosses the R10 counter wrap
      for (int i = 0; i < 320; i++) begin
         logic [15:0] w;
         logic [7:0]  f;
         logic        a, d;
         lf = nxt(lf);
         a = lf[20];
         d = lf[21];
         f = a ? {6'h04, lf[23:22]} : (lf[24] ? 8'h85 : 8'h05);
         case (lf[27:26])
            2'd0: w = enc(ZOP, d, a, f);
            2'd1: w = enc(NZOP, d, a, f);
            2'd2: w = 16'h0000;
            default: w = {6'b001010, d, a, f};
         endcase
         issue(w, lf[28], lf[29] ? 4'h2 : 4'h1);
      end
      finish_run();
   end
endmodule